// File: doc/BRIEF.md
# Programmed-I/O Bridge to a 16-bit Asynchronous Peripheral

This block sits between a 32-bit soft-core memory port and an external controller chip that has a plain asynchronous parallel bus. On the CPU side there is a valid/ready handshake with word address, write data, byte strobes, a write flag and read data. On the device side there is an active-low chip select, active-low read and write strobes, a halfword address and a 16-bit data path. The data path is split into an output value, an output enable and an input value, so that the pad logic elsewhere can build the tri-state driver.

Each accepted CPU request becomes exactly one 16-bit bus cycle on the device side. The cycle has three phases. In the setup phase, chip select and the address are driven with both strobes inactive. In the pulse phase, one strobe is held low. In the hold phase, chip select stays low after the strobe has risen. Each phase lasts a number of clock cycles set by a parameter. There is no width conversion: every device halfword occupies its own 32-bit CPU word slot. The upper half of the CPU data bus is therefore dropped on writes and returned as zero on reads. The two page-select bits at the top of the device address are always zero. Address decoding of the window is done outside this block.

Top module: `pio16_bridge`

## Requirements
- R1: While reset is held and after it is released with no request, chip select, read strobe and write strobe are high, the data output enable is low and CPU ready is low.
- R2: The device address (17 bits, standing for halfword address lines 17..1) carries CPU address bits 16..2 in its bits 14..0 and zero in its bits 16..15. CPU address bits 1..0 and 31..17 have no effect. The address is held stable for the whole time chip select is low.
- R3: For a bus cycle, chip select goes low with a valid address for exactly SETUP_CYC cycles before the strobe falls, with both strobes high during that time.
- R4: A read (write flag low) holds the read strobe low for exactly PULSE_CYC cycles. The device data is sampled on the last of those cycles and returned as cpu_rdata = {16'h0000, sample}.
- R5: A write (write flag high, at least one byte strobe set) holds the write strobe low for exactly PULSE_CYC cycles. The device sees cpu_wdata[15:0]; cpu_wdata[31:16] has no effect.
- R6: On a write, the data output enable is high from the cycle before the write strobe falls until the last hold cycle. At all other times it is low, and it is never high during a read.
- R7: After the strobe rises, chip select stays low for exactly HOLD_CYC cycles and then rises.
- R8: CPU ready is high for exactly one cycle, in the cycle right after the hold phase. The complete latency from the accepting edge to ready is SETUP_CYC+PULSE_CYC+HOLD_CYC+1 cycles.
- R9: A write with all four byte strobes clear runs no bus cycle (chip select stays high) and raises ready in the first cycle after acceptance. The device contents are left unchanged.
- R10: The read and write strobes are never low at the same time, and each request produces exactly one chip-select period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_valid | input | 1 | Request valid; held until ready |
| cpu_write | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 32 | CPU byte address |
| cpu_wdata | input | 32 | Write data; only bits 15..0 are used |
| cpu_wstrb | input | 4 | Byte strobes; all clear on a write means no bus cycle |
| cpu_ready | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 32 | Read data, upper half zero |
| dev_cs_n | output | 1 | Chip select, active low |
| dev_rd_n | output | 1 | Read strobe, active low |
| dev_wr_n | output | 1 | Write strobe, active low |
| dev_addr | output | 17 | Halfword address lines 17..1, top two bits zero |
| dev_dout | output | 16 | Data driven toward the device |
| dev_doe | output | 1 | Output enable for dev_dout |
| dev_din | input | 16 | Data returned from the device |

## Verification
The device model returns the inverted value on every read-strobe cycle except the last one. A bridge that samples too early or too late therefore returns wrong data. Writes are checked by reading the values back through the model. So writes landing at the wrong address, taking data from the upper half, or being triggered by an all-clear strobe pattern all show up as mismatched read data. Every cycle of every transfer is compared against the expected setup, pulse, hold and ready windows. An off-by-one in any phase counter, a data enable that opens late or stays on after hold, or a ready that lasts two cycles is reported in the cycle where it happens. Directed cases cover the highest halfword index, nonzero low address bits, upper-only byte strobes and a write with no strobes. The random mix covers back-to-back transfers.

// File: rtl/pio_bridge_pkg.sv
// Shared types for the programmed-I/O bridge.
// Assumes: nothing beyond standard SystemVerilog.
package pio_bridge_pkg;

    // Phase of the device bus cycle.
    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_SETUP = 3'd1,
        PH_PULSE = 3'd2,
        PH_HOLD  = 3'd3,
        PH_DONE  = 3'd4
    } phase_t;

endpackage

// File: rtl/pio_addr_map.sv
// Maps a CPU byte address to the device halfword address lines.
// Each device halfword sits in one 32-bit CPU word. The device index is
// therefore taken from CPU bit 2 upward, and the page bits on top are zero.
// Assumes: window decoding is done outside; upper CPU bits are don't-care.
module pio_addr_map #(
    parameter int CPU_AW    = 32,
    parameter int DEV_AW    = 17,
    parameter int PAGE_BITS = 2
) (
    input  logic [CPU_AW-1:0] cpu_addr,
    output logic [DEV_AW-1:0] dev_addr
);
    localparam int IDX_W = DEV_AW - PAGE_BITS;

    logic unused_addr_bits;

    // Index bits from the word address, page bits forced to zero.
    always_comb begin
        dev_addr = {{PAGE_BITS{1'b0}}, cpu_addr[IDX_W+1:2]};
    end

    assign unused_addr_bits = ^{cpu_addr[CPU_AW-1:IDX_W+2], cpu_addr[1:0]};

endmodule

// File: rtl/pio_sequencer.sv
// Phase sequencer for one device bus cycle: setup, pulse, hold, done.
// Each phase lasts a parameterised number of cycles, counted by one down-counter.
// A skipped request (empty write) goes straight from idle to done.
// Assumes: SETUP_CYC, PULSE_CYC and HOLD_CYC are all at least 1.
module pio_sequencer
    import pio_bridge_pkg::*;
#(
    parameter int SETUP_CYC = 2,
    parameter int PULSE_CYC = 3,
    parameter int HOLD_CYC  = 2
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   start,
    input  logic   skip,
    output phase_t phase_o,
    output logic   setup_last_o,
    output logic   pulse_last_o
);
    localparam int MAX_SP  = (SETUP_CYC > PULSE_CYC) ? SETUP_CYC : PULSE_CYC;
    localparam int MAX_CYC = (MAX_SP > HOLD_CYC) ? MAX_SP : HOLD_CYC;
    localparam int CNT_W   = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;
    localparam logic [CNT_W-1:0] SETUP_LD = CNT_W'(SETUP_CYC - 1);
    localparam logic [CNT_W-1:0] PULSE_LD = CNT_W'(PULSE_CYC - 1);
    localparam logic [CNT_W-1:0] HOLD_LD  = CNT_W'(HOLD_CYC - 1);

    phase_t           phase_q;
    logic [CNT_W-1:0] cnt_q;
    logic             cnt_zero;

    assign cnt_zero = (cnt_q == '0);

    // Phase and counter update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
        end else begin
            unique case (phase_q)
                PH_IDLE: begin
                    if (start) begin
                        if (skip) begin
                            phase_q <= PH_DONE;
                        end else begin
                            phase_q <= PH_SETUP;
                            cnt_q   <= SETUP_LD;
                        end
                    end
                end
                PH_SETUP: begin
                    if (cnt_zero) begin
                        phase_q <= PH_PULSE;
                        cnt_q   <= PULSE_LD;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                PH_PULSE: begin
                    if (cnt_zero) begin
                        phase_q <= PH_HOLD;
                        cnt_q   <= HOLD_LD;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                PH_HOLD: begin
                    if (cnt_zero) begin
                        phase_q <= PH_DONE;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                PH_DONE: phase_q <= PH_IDLE;
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    assign phase_o      = phase_q;
    assign setup_last_o = (phase_q == PH_SETUP) && cnt_zero;
    assign pulse_last_o = (phase_q == PH_PULSE) && cnt_zero;

    // R9: an empty write reaches done one cycle after acceptance.
    p_skip_to_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_IDLE && start && skip) |=> (phase_q == PH_DONE));

    // R8: done follows hold, or idle for a skipped request, and lasts one cycle.
    p_done_entry_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_DONE) |=> (phase_q == PH_IDLE));

endmodule

// File: rtl/pio_data_path.sv
// Data registers of the bridge: keeps the write halfword for the whole cycle
// and captures the device halfword when told to.
// Assumes: load and capture never occur in the same cycle.
module pio_data_path #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [DW-1:0] wdata_i,
    input  logic          capture,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout_o,
    output logic [DW-1:0] rdata_o
);
    logic [DW-1:0] wr_q;
    logic [DW-1:0] rd_q;

    // Latch write data at request acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n)    wr_q <= '0;
        else if (load) wr_q <= wdata_i;
    end

    // Capture read data on the last strobe cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)       rd_q <= '0;
        else if (capture) rd_q <= din;
    end

    assign dout_o  = wr_q;
    assign rdata_o = rd_q;

endmodule

// File: rtl/pio16_bridge.sv
// Top of the CPU-to-16-bit asynchronous peripheral bridge.
// Accepts one request on valid while idle and runs one timed device bus cycle.
// It then pulses ready for one cycle. A write with no byte strobes skips the bus.
// Assumes: the CPU holds valid, address and data stable until ready, and drops
// valid in the cycle after ready. The tri-state pad sits outside this block.
module pio16_bridge
    import pio_bridge_pkg::*;
#(
    parameter int CPU_AW    = 32,
    parameter int CPU_DW    = 32,
    parameter int DEV_AW    = 17,
    parameter int DEV_DW    = 16,
    parameter int PAGE_BITS = 2,
    parameter int SETUP_CYC = 2,
    parameter int PULSE_CYC = 3,
    parameter int HOLD_CYC  = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cpu_valid,
    input  logic                cpu_write,
    input  logic [CPU_AW-1:0]   cpu_addr,
    input  logic [CPU_DW-1:0]   cpu_wdata,
    input  logic [CPU_DW/8-1:0] cpu_wstrb,
    output logic                cpu_ready,
    output logic [CPU_DW-1:0]   cpu_rdata,
    output logic                dev_cs_n,
    output logic                dev_rd_n,
    output logic                dev_wr_n,
    output logic [DEV_AW-1:0]   dev_addr,
    output logic [DEV_DW-1:0]   dev_dout,
    output logic                dev_doe,
    input  logic [DEV_DW-1:0]   dev_din
);
    localparam int PAD_W = CPU_DW - DEV_DW;

    phase_t              phase;
    logic                setup_last;
    logic                pulse_last;
    logic                accept;
    logic                skip;
    logic                is_wr_q;
    logic [DEV_AW-1:0]   addr_next;
    logic [DEV_AW-1:0]   addr_q;
    logic [DEV_DW-1:0]   rdata_half;
    logic                in_cycle;
    logic                unused_wdata_hi;

    assign accept = cpu_valid && (phase == PH_IDLE);
    assign skip   = cpu_write && (cpu_wstrb == '0);

    pio_addr_map #(
        .CPU_AW   (CPU_AW),
        .DEV_AW   (DEV_AW),
        .PAGE_BITS(PAGE_BITS)
    ) i_addr_map (
        .cpu_addr(cpu_addr),
        .dev_addr(addr_next)
    );

    pio_sequencer #(
        .SETUP_CYC(SETUP_CYC),
        .PULSE_CYC(PULSE_CYC),
        .HOLD_CYC (HOLD_CYC)
    ) i_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (accept),
        .skip        (skip),
        .phase_o     (phase),
        .setup_last_o(setup_last),
        .pulse_last_o(pulse_last)
    );

    pio_data_path #(
        .DW(DEV_DW)
    ) i_data (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (accept),
        .wdata_i(cpu_wdata[DEV_DW-1:0]),
        .capture(pulse_last && !is_wr_q),
        .din    (dev_din),
        .dout_o (dev_dout),
        .rdata_o(rdata_half)
    );

    // Register direction and address at acceptance so they stay fixed for the cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            is_wr_q <= 1'b0;
            addr_q  <= '0;
        end else if (accept) begin
            is_wr_q <= cpu_write;
            addr_q  <= addr_next;
        end
    end

    // Decode device pins from the registered phase.
    always_comb begin
        in_cycle  = (phase == PH_SETUP) || (phase == PH_PULSE) || (phase == PH_HOLD);
        dev_cs_n  = !in_cycle;
        dev_rd_n  = !((phase == PH_PULSE) && !is_wr_q);
        dev_wr_n  = !((phase == PH_PULSE) && is_wr_q);
        dev_doe   = is_wr_q && (setup_last || (phase == PH_PULSE) || (phase == PH_HOLD));
        cpu_ready = (phase == PH_DONE);
    end

    assign dev_addr        = addr_q;
    assign cpu_rdata       = {{PAD_W{1'b0}}, rdata_half};
    assign unused_wdata_hi = ^cpu_wdata[CPU_DW-1:DEV_DW];

    // R10: the two strobes are mutually exclusive.
    p_strobe_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(!dev_rd_n && !dev_wr_n));

    // R3: a strobe is only ever low inside a chip-select period.
    p_strobe_in_cs_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!dev_rd_n || !dev_wr_n) |-> !dev_cs_n);

    // R2: the address does not move while chip select stays low.
    p_addr_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!dev_cs_n && $past(!dev_cs_n)) |-> $stable(dev_addr));

    // R6: data is only driven inside a cycle and never while reading.
    p_doe_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
        dev_doe |-> (!dev_cs_n && dev_rd_n));

    // R7: chip select is still low when a strobe rises.
    p_hold_after_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(dev_rd_n) || $rose(dev_wr_n)) |-> !dev_cs_n);

    // R8: ready is a single-cycle pulse.
    p_ready_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |=> !cpu_ready);

    // Checker counter for strobe width, compared when the strobe rises.
    logic [15:0] chk_low_q;
    always_ff @(posedge clk) begin
        if (!rst_n)                    chk_low_q <= '0;
        else if (!dev_rd_n || !dev_wr_n) chk_low_q <= chk_low_q + 16'd1;
        else                           chk_low_q <= '0;
    end

    // R4, R5: strobe stays low for exactly the pulse count.
    p_pulse_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(dev_rd_n) || $rose(dev_wr_n)) |-> (chk_low_q == 16'(PULSE_CYC)));

endmodule

// File: tb/test_pio16_bridge.sv
// Self-checking bench: register-file model of the device, cycle-by-cycle
// comparison of pin windows, and data checked by readback.
module test_pio16_bridge;
    localparam int S = 2;
    localparam int P = 3;
    localparam int H = 2;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cpu_valid;
    logic        cpu_write;
    logic [31:0] cpu_addr;
    logic [31:0] cpu_wdata;
    logic [3:0]  cpu_wstrb;
    logic        cpu_ready;
    logic [31:0] cpu_rdata;
    logic        dev_cs_n, dev_rd_n, dev_wr_n, dev_doe;
    logic [16:0] dev_addr;
    logic [15:0] dev_dout;
    logic [15:0] dev_din;

    int nchk = 0;
    int nerr = 0;
    bit finished = 1'b0;

    logic [15:0] mdl_mem [64];
    logic [15:0] exp_mem [64];
    int          rd_low_cnt;

    always #5 clk = ~clk;

    pio16_bridge #(.SETUP_CYC(S), .PULSE_CYC(P), .HOLD_CYC(H)) i_pio16_bridge (
        .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid), .cpu_write(cpu_write),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_wstrb(cpu_wstrb),
        .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata), .dev_cs_n(dev_cs_n),
        .dev_rd_n(dev_rd_n), .dev_wr_n(dev_wr_n), .dev_addr(dev_addr),
        .dev_dout(dev_dout), .dev_doe(dev_doe), .dev_din(dev_din)
    );

    function automatic logic [15:0] init_val(input int i);
        return 16'(i * 16'h0101) ^ 16'h5A3C;
    endfunction

    // Device model: write on each low write-strobe edge, count read-strobe cycles.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 64; i++) mdl_mem[i] <= init_val(i);
            rd_low_cnt <= 0;
        end else begin
            if (!dev_wr_n && !dev_cs_n && dev_doe) mdl_mem[dev_addr[5:0]] <= dev_dout;
            rd_low_cnt <= (!dev_rd_n) ? rd_low_cnt + 1 : 0;
        end
    end

    // Correct data only on the last read-strobe cycle, inverted otherwise.
    assign dev_din = (!dev_rd_n && rd_low_cnt == P - 1) ? mdl_mem[dev_addr[5:0]]
                                                       : ~mdl_mem[dev_addr[5:0]];

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
        end
    endtask

    // One transfer with every cycle compared against the expected pin windows.
    task automatic xfer(input bit wr, input logic [31:0] addr, input logic [31:0] wd,
                        input logic [3:0] strb);
        bit          empty = wr && (strb == 4'b0);
        int          last  = empty ? 1 : S + P + H + 1;
        logic [16:0] eaddr = {2'b00, addr[16:2]};
        logic [5:0]  idx   = addr[7:2];
        @(negedge clk);
        cpu_valid = 1'b1; cpu_write = wr; cpu_addr = addr; cpu_wdata = wd; cpu_wstrb = strb;
        for (int k = 1; k <= last; k++) begin
            logic [4:0] e;
            @(negedge clk);
            if (k == last) e = 5'b11101;                                   // cs rd wr oe ready
            else if (k <= S) e = {3'b011, (wr && k == S), 1'b0};
            else if (k <= S + P) e = wr ? 5'b01010 : 5'b00100;
            else e = {3'b011, wr, 1'b0};
            chk({dev_cs_n, dev_rd_n, dev_wr_n, dev_doe, cpu_ready} == e,
                "R3/R4/R5/R6/R7/R8/R9 pins", 32'({dev_cs_n, dev_rd_n, dev_wr_n, dev_doe, cpu_ready}),
                32'(e));
            if (!dev_cs_n) chk(dev_addr == eaddr, "R2 address", 32'(dev_addr), 32'(eaddr));
            if (dev_doe) chk(dev_dout == wd[15:0], "R5 write data", 32'(dev_dout), 32'(wd[15:0]));
            if (k == last && !wr)
                chk(cpu_rdata == {16'h0, exp_mem[idx]}, "R4 read data", cpu_rdata,
                    {16'h0, exp_mem[idx]});
        end
        cpu_valid = 1'b0;
        if (wr && !empty) exp_mem[idx] = wd[15:0];
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            nerr++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 64; i++) exp_mem[i] = init_val(i);
        rst_n = 1'b0; cpu_valid = 1'b0; cpu_write = 1'b0;
        cpu_addr = '0; cpu_wdata = '0; cpu_wstrb = '0;
        repeat (3) @(negedge clk);
        // R1: pins idle during reset
        chk({dev_cs_n, dev_rd_n, dev_wr_n, dev_doe, cpu_ready} == 5'b11100, "R1 in reset",
            32'({dev_cs_n, dev_rd_n, dev_wr_n, dev_doe, cpu_ready}), 32'h1C);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk({dev_cs_n, dev_rd_n, dev_wr_n, dev_doe, cpu_ready} == 5'b11100, "R1 after reset",
            32'({dev_cs_n, dev_rd_n, dev_wr_n, dev_doe, cpu_ready}), 32'h1C);

        // Directed corner cases.
        xfer(1'b0, 32'h0000_0010, '0, 4'h0);                    // R4 plain read
        xfer(1'b1, 32'hFFFF_FFFF, 32'hABCD_1234, 4'hF);         // R2 top index, low bits set
        chk(dev_addr == 17'h07FFF, "R2 highest index", 32'(dev_addr), 32'h7FFF);
        xfer(1'b0, 32'h0001_FFFC, '0, 4'h0);                    // R2 readback of top index
        xfer(1'b1, 32'h0000_0022, 32'hFFFF_0042, 4'hC);         // R5 upper strobes only
        xfer(1'b0, 32'h0000_0020, '0, 4'h0);                    // R5 upper half ignored
        xfer(1'b1, 32'h0000_0020, 32'h0000_BEEF, 4'h0);         // R9 empty write
        xfer(1'b0, 32'h0000_0020, '0, 4'h0);                    // R9 contents unchanged

        // Random mix.
        for (int n = 0; n < 300; n++) begin
            bit          w = $urandom_range(0, 1) == 1;
            logic [3:0]  s = ($urandom_range(0, 7) == 0) ? 4'h0 : 4'($urandom_range(1, 15));
            xfer(w, $urandom(), $urandom(), s);                  // R10 one cycle per request
        end

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule